// File: doc/BRIEF.md
# Delayed-Read Buffer Discard Timer

This block manages a pool of eight delayed-read transaction buffers, each sized for one 32-byte cache line, and gives every buffer its own discard timer. A requester asks for a buffer and tags it prefetchable or non-prefetchable. Read data later completes into the buffer, and the originating master eventually comes back and collects it. If a master that owns a non-prefetchable read never returns, that buffer stays stuck. The timer frees it after a programmed number of internal clock cycles. Prefetched buffers have no timer. When the pool is full, the oldest-index prefetched entry is evicted instead.

A 32-bit control register holds an enable flag and a 24-bit preload value P. Each timer is loaded with P and counts up to its 24-bit wrap, so the timeout is 2^24 − P cycles. For example, P = 0xFF0000 gives 2^16 internal cycles, which is 2^15 bus clocks when the internal clock runs at twice the bus clock. The all-ones preload is not legal. The block reports it as a configuration error and refuses to start any timer with it.

Top module: `drb_discard_timer`

## Requirements
- R1: After reset the control register reads 0x00000000, the configuration error flag is low, no buffer is occupied, and no release or discard pulse is asserted.
- R2: In the control register, bit 31 enables the timers and bits 23:0 hold the preload value. Bits 30:24 always read zero, and writes to them are ignored.
- R3: The configuration error output is high exactly while the preload equals 0xFFFFFF. While it is high, no timer is loaded, counted or allowed to discard. A buffer that completed during that time is armed with the new preload on the cycle after a legal value is written.
- R4: A non-prefetchable allocate takes the lowest-index free buffer of the whole pool. Buffers 0 and 1 can only ever hold non-prefetchable reads.
- R5: A prefetchable allocate takes the lowest-index free buffer at index 2 or above.
- R6: If no permitted buffer is free, the allocate evicts the lowest-index buffer holding a prefetched read. It acknowledges with that index and pulses that buffer's release bit on the next cycle. If no prefetched entry exists, the request gets a retry response and no acknowledge.
- R7: A non-prefetchable buffer filled at clock edge E, with the timers enabled and the preload P legal, is discarded at edge E + (2^24 − P). Its discard bit and release bit are then high together for exactly one cycle.
- R8: A retrieve strobe on a filled buffer frees it and pulses only its release bit on the next cycle. A retrieve strobe on a free buffer, or on one still waiting for data, has no effect.
- R9: A non-prefetchable buffer is never released except by a retrieve strobe or by expiry of its own timer.
- R10: While the enable flag is clear, every timer holds its count and no discard occurs. When the flag is set again, counting resumes from the held count, so the timeout grows by exactly the number of disabled cycles.
- R11: Timers that expire on the same edge release all of their buffers together, each with its own one-cycle discard pulse.
- R12: A buffer holding a prefetched read is never discarded by a timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| cfg_err | output | 1 | Illegal preload programmed |
| alloc_req | input | 1 | Buffer allocate request |
| alloc_np | input | 1 | 1 = non-prefetchable read, 0 = prefetchable |
| alloc_ack | output | 1 | Allocate accepted (same cycle) |
| alloc_retry | output | 1 | Allocate refused, requester must retry (same cycle) |
| alloc_idx | output | 3 | Index of the granted buffer |
| fill_vld | input | 1 | Read data has completed into a buffer |
| fill_idx | input | 3 | Buffer that completed |
| rtv_vld | input | 1 | Originating master collects its data |
| rtv_idx | input | 3 | Buffer being collected |
| buf_release | output | 8 | One-cycle pulse per buffer freed for any reason |
| buf_discard | output | 8 | One-cycle pulse per buffer freed by timer expiry |

## Verification
Allocation is tried on a filling pool, on a full pool with prefetched entries, and on a full pool of non-prefetchable entries. These three cases separate the free-buffer search, the reserved-buffer rule, eviction and retry. Timers are tried in four ways: one fill with the timers enabled, two fills made while the preload was illegal and armed on the same edge, a fill with a disabled gap in the middle, and a fill collected before its timeout. The scoreboard compares the exact discard cycle in each case. This tells apart an off-by-one timeout, a timer that counts while frozen, expiries that are not released together, and a timer that fires after its buffer was collected.

// File: rtl/drb_pkg.sv
package drb_pkg;

   typedef enum logic [1:0] {
      SL_FREE = 2'd0,
      SL_PEND = 2'd1,
      SL_HELD = 2'd2
   } slot_st_e;

endpackage

// File: rtl/drb_cfg_reg.sv
module drb_cfg_reg #(
   parameter int REG_W = 32,
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             enable,
   output logic [TMR_W-1:0] preload,
   output logic             bad_preload
);
   localparam int RSV_W = REG_W - 1 - TMR_W;

   generate
      if (TMR_W >= REG_W) begin : g_bad_w
         $error("TMR_W must leave room for the enable bit");
      end
   endgenerate

   logic             en_q;
   logic [TMR_W-1:0] pre_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         pre_q <= '0;
      end else if (we) begin
         en_q  <= wdata[REG_W-1];
         pre_q <= wdata[TMR_W-1:0];
      end
   end

   generate
      if (RSV_W > 0) begin : g_rsv
         logic cfg_unused;
         assign cfg_unused = ^wdata[REG_W-2:TMR_W];
         assign rdata = {en_q, {RSV_W{1'b0}}, pre_q};
      end else begin : g_norsv
         assign rdata = {en_q, pre_q};
      end
   endgenerate

   assign enable      = en_q;
   assign preload     = pre_q;
   assign bad_preload = &pre_q;

endmodule

// File: rtl/drb_alloc.sv
module drb_alloc #(
   parameter int NUM_BUF = 8,
   parameter int NP_RSVD = 2,
   localparam int IDX_W  = $clog2(NUM_BUF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic               np,
   input  logic [NUM_BUF-1:0] busy_vec,
   input  logic [NUM_BUF-1:0] pf_vec,
   output logic [NUM_BUF-1:0] grant_vec,
   output logic               ack,
   output logic               retry,
   output logic               evict,
   output logic [IDX_W-1:0]   idx
);
   generate
      if (NP_RSVD >= NUM_BUF) begin : g_bad_rsvd
         $error("NP_RSVD must leave buffers for prefetched reads");
      end
   endgenerate

   logic [NUM_BUF-1:0] allow;
   logic [NUM_BUF-1:0] cand;
   logic               found;
   logic               evict_c;
   logic [IDX_W-1:0]   pick;

   generate
      for (genvar g = 0; g < NUM_BUF; g++) begin : g_allow
         if (g < NP_RSVD) begin : g_np_only
            assign allow[g] = np;
         end else begin : g_shared
            assign allow[g] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      cand    = ~busy_vec & allow;
      found   = 1'b0;
      evict_c = 1'b0;
      pick    = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (cand[i] && !found) begin
            found = 1'b1;
            pick  = IDX_W'(i);
         end
      end
      if (!found) begin
         for (int i = 0; i < NUM_BUF; i++) begin
            if (pf_vec[i] && !found) begin
               found   = 1'b1;
               evict_c = 1'b1;
               pick    = IDX_W'(i);
            end
         end
      end
   end

   assign ack       = req && found;
   assign retry     = req && !found;
   assign evict     = ack && evict_c;
   assign idx       = pick;
   assign grant_vec = ack ? (NUM_BUF'(1) << pick) : '0;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec)); // R4
   AST_PF_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !np) |-> (int'(idx) >= NP_RSVD)); // R5
   AST_EVICT_ONLY_PF: assert property (@(posedge clk) disable iff (!rst_n)
      evict |-> pf_vec[idx]); // R6
   AST_GRANT_NOT_NP: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (!busy_vec[idx] || pf_vec[idx])); // R9

endmodule

// File: rtl/drb_slot.sv
module drb_slot
   import drb_pkg::*;
#(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_hit,
   input  logic             alloc_np,
   input  logic             fill_hit,
   input  logic             rtv_hit,
   input  logic             tick_en,
   input  logic             arm_ok,
   input  logic [TMR_W-1:0] preload,
   output logic             busy,
   output logic             pf_occ,
   output logic             release_o,
   output logic             discard_o
);
   localparam logic [TMR_W-1:0] CNT_MAX = '1;

   slot_st_e         st_q;
   logic             np_q;
   logic             armed_q;
   logic [TMR_W-1:0] cnt_q;
   logic             expire;

   assign expire = (st_q == SL_HELD) && np_q && armed_q && tick_en && (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= SL_FREE;
         np_q      <= 1'b0;
         armed_q   <= 1'b0;
         cnt_q     <= '0;
         release_o <= 1'b0;
         discard_o <= 1'b0;
      end else begin
         release_o <= 1'b0;
         discard_o <= 1'b0;
         if (alloc_hit) begin
            if (st_q != SL_FREE) release_o <= 1'b1;
            st_q    <= SL_PEND;
            np_q    <= alloc_np;
            armed_q <= 1'b0;
         end else if ((st_q == SL_HELD) && rtv_hit) begin
            st_q      <= SL_FREE;
            armed_q   <= 1'b0;
            release_o <= 1'b1;
         end else if ((st_q == SL_PEND) && fill_hit) begin
            st_q    <= SL_HELD;
            cnt_q   <= preload;
            armed_q <= np_q && arm_ok;
         end else if ((st_q == SL_HELD) && np_q) begin
            if (!armed_q) begin
               if (arm_ok) begin
                  cnt_q   <= preload;
                  armed_q <= 1'b1;
               end
            end else if (expire) begin
               st_q      <= SL_FREE;
               armed_q   <= 1'b0;
               release_o <= 1'b1;
               discard_o <= 1'b1;
            end else if (tick_en) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign busy   = (st_q != SL_FREE);
   assign pf_occ = (st_q != SL_FREE) && !np_q;

   AST_DISCARD_IS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      discard_o |-> release_o); // R7
   AST_NP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SL_HELD) && np_q && !rtv_hit && !expire) |=> !release_o); // R9
   AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SL_HELD) && armed_q && !tick_en && !rtv_hit) |=> $stable(cnt_q)); // R10
   AST_PF_NO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != SL_HELD) || !np_q) |=> !discard_o); // R12

endmodule

// File: rtl/drb_discard_timer.sv
module drb_discard_timer #(
   parameter int NUM_BUF = 8,
   parameter int NP_RSVD = 2,
   parameter int REG_W   = 32,
   parameter int TMR_W   = 24,
   localparam int IDX_W  = $clog2(NUM_BUF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic [REG_W-1:0]   cfg_rdata,
   output logic               cfg_err,
   input  logic               alloc_req,
   input  logic               alloc_np,
   output logic               alloc_ack,
   output logic               alloc_retry,
   output logic [IDX_W-1:0]   alloc_idx,
   input  logic               fill_vld,
   input  logic [IDX_W-1:0]   fill_idx,
   input  logic               rtv_vld,
   input  logic [IDX_W-1:0]   rtv_idx,
   output logic [NUM_BUF-1:0] buf_release,
   output logic [NUM_BUF-1:0] buf_discard
);
   generate
      if (NUM_BUF < 2) begin : g_bad_nb
         $error("NUM_BUF must be at least 2");
      end
   endgenerate

   logic             tmr_en;
   logic [TMR_W-1:0] tmr_pre;
   logic             pre_bad;
   logic             tick_en;
   logic             arm_ok;
   logic             evict_unused;

   logic [NUM_BUF-1:0] busy_vec;
   logic [NUM_BUF-1:0] pf_vec;
   logic [NUM_BUF-1:0] grant_vec;

   drb_cfg_reg #(.REG_W(REG_W), .TMR_W(TMR_W)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (cfg_we),
      .wdata       (cfg_wdata),
      .rdata       (cfg_rdata),
      .enable      (tmr_en),
      .preload     (tmr_pre),
      .bad_preload (pre_bad)
   );

   assign cfg_err = pre_bad;
   assign arm_ok  = !pre_bad;
   assign tick_en = tmr_en && !pre_bad;

   drb_alloc #(.NUM_BUF(NUM_BUF), .NP_RSVD(NP_RSVD)) u_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (alloc_req),
      .np        (alloc_np),
      .busy_vec  (busy_vec),
      .pf_vec    (pf_vec),
      .grant_vec (grant_vec),
      .ack       (alloc_ack),
      .retry     (alloc_retry),
      .evict     (evict_unused),
      .idx       (alloc_idx)
   );

   generate
      for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
         drb_slot #(.TMR_W(TMR_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_hit (grant_vec[g]),
            .alloc_np  (alloc_np),
            .fill_hit  (fill_vld && (fill_idx == IDX_W'(g))),
            .rtv_hit   (rtv_vld && (rtv_idx == IDX_W'(g))),
            .tick_en   (tick_en),
            .arm_ok    (arm_ok),
            .preload   (tmr_pre),
            .busy      (busy_vec[g]),
            .pf_occ    (pf_vec[g]),
            .release_o (buf_release[g]),
            .discard_o (buf_discard[g])
         );
      end
   endgenerate

   AST_ERR_NO_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> (buf_discard == '0)); // R3
   AST_ACK_XOR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req |-> (alloc_ack != alloc_retry)); // R6

endmodule

// File: tb/tb_drb_discard_timer.sv
module tb_drb_discard_timer;
   localparam int  NB  = 8;
   localparam longint TMO = 16;   // preload 0xFFFFF0
   localparam logic [31:0] CFG_RUN = 32'h80FF_FFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        cfg_err;
   logic        alloc_req = 1'b0, alloc_np = 1'b0;
   logic        alloc_ack, alloc_retry;
   logic [2:0]  alloc_idx;
   logic        fill_vld = 1'b0;
   logic [2:0]  fill_idx = '0;
   logic        rtv_vld = 1'b0;
   logic [2:0]  rtv_idx = '0;
   logic [NB-1:0] buf_release, buf_discard;

   int     n_tests = 0;
   int     n_fail  = 0;
   longint cyc = 0;
   bit     mon_on = 1'b0;
   int     q_idx[$];
   longint q_cyc[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   drb_discard_timer dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .alloc_req(alloc_req),
      .alloc_np(alloc_np), .alloc_ack(alloc_ack), .alloc_retry(alloc_retry),
      .alloc_idx(alloc_idx), .fill_vld(fill_vld), .fill_idx(fill_idx),
      .rtv_vld(rtv_vld), .rtv_idx(rtv_idx), .buf_release(buf_release),
      .buf_discard(buf_discard)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every discard pulse must match the next expected item
   always @(negedge clk) begin : mon
      int     ei;
      longint ec;
      if (mon_on) begin
         for (int i = 0; i < NB; i++) begin
            if (buf_discard[i]) begin
               if (q_idx.size() == 0) begin
                  chk(1'b0, "R9 unexpected discard of buffer", i, -1);
               end else begin
                  ei = q_idx.pop_front();
                  ec = q_cyc.pop_front();
                  chk(ei == i, "R7 discard buffer index", i, ei);
                  chk(ec == cyc, "R7 discard cycle", cyc, ec);
                  chk(buf_release[i], "R7 discard without release", 0, 1);
               end
            end
         end
      end
   end

   task automatic push_exp(input int idx, input longint at);
      q_idx.push_back(idx);
      q_cyc.push_back(at);
   endtask

   task automatic wr(input logic [31:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_alloc(input bit np, input bit exp_ack, input int exp_idx,
                           input bit exp_evict, input string tag);
      alloc_req = 1'b1; alloc_np = np;
      #1;
      chk(alloc_ack == exp_ack, {tag, " alloc ack"}, alloc_ack, exp_ack);
      chk(alloc_retry == !exp_ack, {tag, " alloc retry"}, alloc_retry, !exp_ack);
      if (exp_ack) chk(alloc_idx == exp_idx, {tag, " alloc index"}, alloc_idx, exp_idx);
      @(posedge clk); @(negedge clk);
      alloc_req = 1'b0;
      chk(buf_release == (exp_evict ? (NB'(1) << exp_idx) : '0),
          {tag, " eviction release"}, buf_release, exp_evict ? (1 << exp_idx) : 0);
   endtask

   task automatic do_fill(input int idx, input bit exp_timer, input longint extra);
      fill_vld = 1'b1; fill_idx = 3'(idx);
      @(posedge clk); @(negedge clk);
      fill_vld = 1'b0;
      if (exp_timer) push_exp(idx, cyc + TMO + extra);
   endtask

   task automatic do_rtv(input int idx, input bit exp_rel, input string tag);
      rtv_vld = 1'b1; rtv_idx = 3'(idx);
      @(posedge clk); @(negedge clk);
      rtv_vld = 1'b0;
      chk(buf_release == (exp_rel ? (NB'(1) << idx) : '0), {tag, " retrieve release"},
          buf_release, exp_rel ? (1 << idx) : 0);
      chk(buf_discard == '0, {tag, " retrieve no discard"}, buf_discard, 0);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(cfg_rdata == 32'h0, "R1 register reset", cfg_rdata, 0);
      chk(cfg_err == 1'b0, "R1 error flag reset", cfg_err, 0);
      chk(buf_release == '0 && buf_discard == '0, "R1 pulses reset", buf_release, 0);
      mon_on = 1'b1;

      wr(32'hFFFF_FFFF);
      chk(cfg_rdata == 32'h80FF_FFFF, "R2 reserved bits read zero", cfg_rdata, 32'h80FF_FFFF);
      chk(cfg_err == 1'b1, "R3 illegal preload flagged", cfg_err, 1);
      wr(CFG_RUN);
      chk(cfg_rdata == CFG_RUN, "R2 register readback", cfg_rdata, CFG_RUN);
      chk(cfg_err == 1'b0, "R3 legal preload clears flag", cfg_err, 0);

      // allocation order and eviction
      do_alloc(1, 1, 0, 0, "R4");
      do_alloc(0, 1, 2, 0, "R5");
      do_alloc(1, 1, 1, 0, "R4");
      do_alloc(1, 1, 3, 0, "R4");
      for (int k = 4; k < NB; k++) do_alloc(0, 1, k, 0, "R5");
      do_alloc(1, 1, 2, 1, "R6");
      do_alloc(0, 1, 4, 1, "R6");
      do_rtv(5, 0, "R8 pending");
      do_fill(5, 0, 0);
      do_rtv(5, 1, "R8");
      do_alloc(0, 1, 5, 0, "R5");

      // fills while preload illegal, then armed on one edge
      wr(32'h80FF_FFFF);
      do_fill(0, 0, 0);
      do_fill(1, 0, 0);
      do_fill(6, 0, 0);
      repeat (40) @(negedge clk);
      chk(cfg_err == 1'b1, "R3 flag holds", cfg_err, 1);
      wr(CFG_RUN);
      push_exp(0, cyc + 1 + TMO);
      push_exp(1, cyc + 1 + TMO);
      repeat (25) @(negedge clk);
      chk(q_idx.size() == 0, "R11 both expiries seen", q_idx.size(), 0);
      do_rtv(6, 1, "R12");

      // single enabled timer
      do_fill(2, 1, 0);
      repeat (20) @(negedge clk);
      chk(q_idx.size() == 0, "R7 expiry seen", q_idx.size(), 0);

      // freeze for 10 cycles in the middle
      do_fill(3, 1, 10);
      repeat (4) @(negedge clk);
      wr(32'h00FF_FFF0);
      repeat (9) @(negedge clk);
      wr(CFG_RUN);
      repeat (25) @(negedge clk);
      chk(q_idx.size() == 0, "R10 frozen expiry seen", q_idx.size(), 0);

      // collected before timeout
      do_alloc(1, 1, 0, 0, "R4");
      do_fill(0, 0, 0);
      repeat (5) @(negedge clk);
      do_rtv(0, 1, "R8");
      repeat (30) @(negedge clk);

      // drain prefetched entries, fill pool with non-prefetchable, then retry
      do_fill(4, 0, 0); do_rtv(4, 1, "R8");
      do_fill(5, 0, 0); do_rtv(5, 1, "R8");
      do_fill(7, 0, 0); do_rtv(7, 1, "R8");
      for (int k = 0; k < NB; k++) do_alloc(1, 1, k, 0, "R4");
      do_alloc(1, 0, 0, 0, "R6 np retry");
      do_alloc(0, 0, 0, 0, "R6 pf retry");

      repeat (5) @(negedge clk);
      chk(q_idx.size() == 0, "R9 scoreboard empty", q_idx.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule